// File: doc/BRIEF.md
# Interleaved Modular Multiplier with Deferred Correction

This block computes `X * Y mod P` for N-bit operands by scanning the multiplier `Y` one bit per clock, most significant bit first, in a double-and-add loop. The running sum is never reduced by `P` inside the loop. Each pass keeps only the N low bits of the sum. The one or two bits that spill over the top form an overflow code. On the next pass, that code and the next multiplier bit pick one ready-made addend from a small table. One adder therefore does all the work of each pass.

When a job is accepted, a short sequencer fills the correction table one entry per clock. It derives the powers of two modulo `P` by repeated modular doubling and combines them with `X`. After the last multiplier bit, a fold step adds back the weight of the final overflow. Two conditional subtractions of `P` then bring the value into `[0, P)`. The result is registered, and `done` pulses for one cycle. The latency is fixed at N + 10 cycles.

The modulus must have its top bit set and must not equal 2^(N-1). `X` must be below `P`. `Y` may be any N-bit value. Use is start-and-wait: raise `start` while `busy` is low, then collect `result` on the `done` pulse.

Top module: `ilv_modmul`

## Requirements
- R1: For 2^(N-1) < P < 2^N, X < P and any N-bit Y, the value on `result` during the `done` pulse equals X*Y mod P.
- R2: `done` is high for exactly one cycle. It is high in the cycle that follows the (N+10)th rising edge after the edge at which `start` was accepted.
- R3: `busy` is high from the cycle after acceptance up to the cycle before `done`. It is low during the `done` cycle, so a new `start` can be accepted in that cycle.
- R4: `start` raised while `busy` is high is ignored. The running job's operands and result are unaffected, and no additional `done` pulse follows.
- R5: `result` keeps its value between `done` pulses, including while a later job is running.
- R6: While reset is held, `busy` and `done` are 0 and `result` is 0.
- R7: Before truncation, the loop sum's overflow code never exceeds 2. Operands at full scale (X = P-1, Y all ones) still give the exact product.
- R8: The correction table is rebuilt from each job's own X and P, and every entry read from it is below P. Back-to-back jobs with different moduli are independent of each other.
- R9: A zero value of X or of Y gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new multiplication; sampled only while idle |
| x_in | input | N | Multiplicand, must be below p_in |
| y_in | input | N | Multiplier, scanned most significant bit first |
| p_in | input | N | Modulus, top bit set, above 2^(N-1) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | N | Registered X*Y mod P of the last completed job |

## Verification
A prime modulus with mid-range operands exercises the main path. Zero multiplicands and zero multipliers check that empty table entries contribute nothing. The full-scale operand X = P-1 with Y all ones drives the overflow code to its largest value on nearly every pass. The extreme moduli 2^(N-1)+1 and 2^N-1, plus an even modulus, separate the three correction weights and the two final subtractions. A run of back-to-back jobs with a different pseudo-random modulus each time would expose a stale correction table. A start pulse injected mid-job shows whether a busy request leaks into the datapath.

// File: rtl/mmi_pkg.sv
package mmi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOOP,
    ST_FOLD,
    ST_RED
  } mm_state_e;

  localparam int TBL_AW    = 3;
  localparam int PRE_STEPS = 7;

  // Table address map: loop passes use {overflow[1:0], y_bit}
  localparam logic [TBL_AW-1:0] IDX_ZERO = 3'b000; // 0
  localparam logic [TBL_AW-1:0] IDX_X    = 3'b001; // X
  localparam logic [TBL_AW-1:0] IDX_K2   = 3'b010; // 2^(N+1) mod P
  localparam logic [TBL_AW-1:0] IDX_XK2  = 3'b011; // X + 2^(N+1) mod P
  localparam logic [TBL_AW-1:0] IDX_K3   = 3'b100; // 2^(N+2) mod P
  localparam logic [TBL_AW-1:0] IDX_XK3  = 3'b101; // X + 2^(N+2) mod P
  localparam logic [TBL_AW-1:0] IDX_K1   = 3'b110; // 2^N mod P, fold only

  // Fold step restores overflow weight ov * 2^N without a doubling
  function automatic logic [TBL_AW-1:0] fold_index(input logic [1:0] ov);
    case (ov)
      2'd0:    fold_index = IDX_ZERO;
      2'd1:    fold_index = IDX_K1;
      default: fold_index = IDX_K2;
    endcase
  endfunction

endpackage

// File: rtl/mmi_mod_add.sv
module mmi_mod_add #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] p,
  output logic [N-1:0] sum
);
  logic [N:0] wide;
  logic [N:0] diff;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    diff = wide - {1'b0, p};
    sum  = (wide >= {1'b0, p}) ? diff[N-1:0] : wide[N-1:0];
  end
endmodule

// File: rtl/mmi_corr_ram.sv
module mmi_corr_ram #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mmi_precomp.sv
module mmi_precomp
  import mmi_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic [N-1:0]      x_op,
  input  logic [N-1:0]      p_op,
  output logic              wr_en,
  output logic [TBL_AW-1:0] wr_addr,
  output logic [N-1:0]      wr_data,
  output logic              last
);
  localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};
  localparam logic [2:0]   LAST_STEP = 3'(PRE_STEPS - 1);

  logic         active;
  logic [2:0]   step;
  logic [N-1:0] k_q, k2_q;
  logic [N-1:0] op_a, op_b, madd;

  mmi_mod_add #(.N(N)) u_madd (
    .a  (op_a),
    .b  (op_b),
    .p  (p_op),
    .sum(madd)
  );

  // One table entry per step; doubling chain 2^N -> 2^(N+1) -> 2^(N+2)
  always_comb begin
    op_a    = k_q;
    op_b    = k_q;
    wr_addr = IDX_ZERO;
    wr_data = '0;
    case (step)
      3'd0: begin wr_addr = IDX_ZERO; wr_data = '0; end
      3'd1: begin wr_addr = IDX_X;    wr_data = x_op; end
      3'd2: begin op_a = HALF; op_b = HALF; wr_addr = IDX_K1; wr_data = madd; end
      3'd3: begin wr_addr = IDX_K2; wr_data = madd; end
      3'd4: begin wr_addr = IDX_K3; wr_data = madd; end
      3'd5: begin op_a = x_op; op_b = k2_q; wr_addr = IDX_XK2; wr_data = madd; end
      3'd6: begin op_a = x_op; op_b = k_q;  wr_addr = IDX_XK3; wr_data = madd; end
      default: begin wr_addr = IDX_ZERO; wr_data = '0; end
    endcase
    wr_en = active;
    last  = active && (step == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      step   <= '0;
      k_q    <= '0;
      k2_q   <= '0;
    end else if (kick) begin
      active <= 1'b1;
      step   <= '0;
    end else if (active) begin
      step <= step + 3'd1;
      if (last) active <= 1'b0;
      if (step == 3'd2 || step == 3'd3 || step == 3'd4) k_q <= madd;
      if (step == 3'd3) k2_q <= madd;
    end
  end

  // R8
  pre_reduced_chk: assert property (@(posedge clk) disable iff (rst)
    (active && step >= 3'd2) |-> (madd < p_op));

endmodule

// File: rtl/mmi_accum.sv
module mmi_accum #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         do_loop,
  input  logic         do_fold,
  input  logic         do_red,
  input  logic [N-1:0] addend,
  input  logic [N-1:0] p_op,
  output logic [1:0]   ov,
  output logic [N-1:0] red_out
);
  logic [N-1:0] r_q;
  logic [1:0]   ov_q;
  logic [N:0]   s_q;
  logic [N+1:0] loop_sum;
  logic [N:0]   fold_sum;
  logic [N:0]   red_full;

  always_comb begin
    loop_sum = {1'b0, r_q, 1'b0} + {2'b00, addend};
    fold_sum = {1'b0, r_q} + {1'b0, addend};
    red_full = (s_q >= {1'b0, p_op}) ? (s_q - {1'b0, p_op}) : s_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q  <= '0;
      ov_q <= '0;
      s_q  <= '0;
    end else if (clr) begin
      r_q  <= '0;
      ov_q <= '0;
    end else if (do_loop) begin
      {ov_q, r_q} <= loop_sum;
    end else if (do_fold) begin
      s_q <= fold_sum;
    end else if (do_red) begin
      s_q <= red_full;
    end
  end

  assign ov      = ov_q;
  assign red_out = red_full[N-1:0];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    do_loop |-> (loop_sum[N+1:N] != 2'b11));

endmodule

// File: rtl/ilv_modmul.sv
module ilv_modmul
  import mmi_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N-1:0] p_in,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  localparam int CW = $clog2(N + 1);

  mm_state_e         st;
  logic [N-1:0]      x_q, y_q, p_q, res_q;
  logic [CW-1:0]     cnt;
  logic              busy_q, done_q;
  logic              kick;
  logic              pre_we, pre_last;
  logic [TBL_AW-1:0] pre_addr, rd_addr;
  logic [N-1:0]      pre_data, tbl_q, red_out;
  logic [1:0]        ov;

  assign kick    = (st == ST_IDLE) && start;
  assign rd_addr = (st == ST_FOLD) ? fold_index(ov) : {ov, y_q[N-1]};

  mmi_precomp #(.N(N)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .kick   (kick),
    .x_op   (x_q),
    .p_op   (p_q),
    .wr_en  (pre_we),
    .wr_addr(pre_addr),
    .wr_data(pre_data),
    .last   (pre_last)
  );

  mmi_corr_ram #(.W(N), .AW(TBL_AW)) u_tbl (
    .clk  (clk),
    .we   (pre_we),
    .waddr(pre_addr),
    .wdata(pre_data),
    .raddr(rd_addr),
    .rdata(tbl_q)
  );

  mmi_accum #(.N(N)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr    (kick),
    .do_loop(st == ST_LOOP),
    .do_fold(st == ST_FOLD),
    .do_red (st == ST_RED),
    .addend (tbl_q),
    .p_op   (p_q),
    .ov     (ov),
    .red_out(red_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      p_q    <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          x_q    <= x_in;
          y_q    <= y_in;
          p_q    <= p_in;
          busy_q <= 1'b1;
          st     <= ST_PRE;
        end
        ST_PRE: if (pre_last) begin
          st  <= ST_LOOP;
          cnt <= '0;
        end
        ST_LOOP: begin
          y_q <= {y_q[N-2:0], 1'b0};
          cnt <= cnt + CW'(1);
          if (cnt == CW'(N - 1)) st <= ST_FOLD;
        end
        ST_FOLD: begin
          st  <= ST_RED;
          cnt <= '0;
        end
        ST_RED: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(1)) begin
            st     <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            res_q  <= red_out;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;

  // R1
  result_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (res_q < p_q));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R3
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R4
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> ($stable(p_q) && $stable(x_q)));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(res_q));

  // R8
  table_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOP || st == ST_FOLD) |-> (tbl_q < p_q));

endmodule

// File: tb/ilv_modmul_tb.sv
`timescale 1ns/1ps
module ilv_modmul_tb;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] x_in = '0, y_in = '0, p_in = '0;
  wire          busy, done;
  wire  [N-1:0] result;

  always #10 clk = ~clk;

  ilv_modmul #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .x_in(x_in), .y_in(y_in), .p_in(p_in),
    .busy(busy), .done(done), .result(result)
  );

  int n_run = 0, n_fail = 0, cyc = 0, extra_done = 0;
  bit busy_bad = 1'b0, prev_done = 1'b0;
  logic [N-1:0] exp_res[$];
  int           exp_cyc[$];
  logic [N-1:0] e_val;
  int           e_cyc;
  logic [31:0]  seed = 32'h1badf00d;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] m);
    longint t;
    t = (longint'(a) * longint'(b)) % longint'(m);
    return t[N-1:0];
  endfunction

  function automatic logic [31:0] lcg(logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  // driver: waits for idle, issues start, pushes expected item
  task automatic run_job(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] m);
    int c;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; x_in = a; y_in = b; p_in = m;
    c = cyc;
    @(posedge clk);
    exp_res.push_back(ref_mul(a, b, m));
    exp_cyc.push_back(c + N + 11);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic poke_busy(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] m);
    @(negedge clk);
    while (!busy) @(negedge clk);
    repeat (3) @(negedge clk);
    start = 1'b1; x_in = a; y_in = b; p_in = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_res.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (done && prev_done) chk(1'b0, "R2", "done wider than one cycle", 2, 1);
        if (done) begin
          if (exp_res.size() == 0) begin
            extra_done++;
          end else begin
            e_val = exp_res.pop_front();
            e_cyc = exp_cyc.pop_front();
            chk(result == e_val, "R1", "product", result, e_val);
            chk(cyc == e_cyc, "R2", "done cycle", cyc, e_cyc);
            chk(!busy && !busy_bad, "R3", "busy window", busy | busy_bad, 0);
            busy_bad = 1'b0;
          end
        end else if (busy != (exp_res.size() != 0)) begin
          busy_bad = 1'b1;
        end
        prev_done = done;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: got no completion expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] held, pr, xr, yr;
    repeat (3) @(negedge clk);
    // R6 reset values
    chk(busy == 1'b0, "R6", "busy in reset", busy, 0);
    chk(done == 1'b0, "R6", "done in reset", done, 0);
    chk(result == '0, "R6", "result in reset", result, 0);
    rst = 1'b0;

    run_job(16'd12345, 16'd54321, 16'd65521);        // R1 prime modulus
    drain();
    held = result;
    repeat (20) @(negedge clk);
    chk(result == held && !done, "R5", "result hold while idle", result, held);

    run_job(16'd0, 16'hBEEF, 16'd65521);             // R9 X zero
    run_job(16'h1234, 16'd0, 16'd65521);             // R9 Y zero
    run_job(16'd65520, 16'hFFFF, 16'd65521);         // R7 full scale
    run_job(16'h8000, 16'hFFFF, 16'h8001);           // R7 smallest modulus
    run_job(16'hFFFE, 16'hFFFF, 16'hFFFF);           // R1 largest modulus
    run_job(16'hBFFF, 16'hBFFF, 16'hC000);           // R1 even modulus
    drain();

    // R4 start while busy, R5 hold while next job runs
    held = result;
    run_job(16'd100, 16'd200, 16'd40009);
    poke_busy(16'd1, 16'd1, 16'h9001);
    chk(result == held, "R5", "result hold during job", result, held);
    drain();

    // R8 back-to-back jobs, fresh modulus each time
    for (int i = 0; i < 12; i++) begin
      seed = lcg(seed); pr = 16'h8001 + 16'(seed[31:8] % 32'h7FFE);
      seed = lcg(seed); xr = 16'(seed[31:8] % {16'h0, pr});
      seed = lcg(seed); yr = seed[23:8];
      run_job(xr, yr, pr);
    end
    drain();
    repeat (N + 20) @(negedge clk);
    chk(extra_done == 0, "R4", "spurious done count", extra_done, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule